// File: doc/BRIEF.md
# Fill ECC Error Logging Unit

This block sits beside the memory/system port of a processor core and watches the ECC check results on data that arrives to fill a cache or leaves as a victim. When the checker reports a single-bit correctable error, the block is told which event produced the data. It then decides the response. An instruction-cache fill error makes the block poison the parity of the affected octaword, flush the instruction cache, log the error and demand an immediate machine check. A data-cache fill error is logged and reported through a corrected-read-data (CRD) interrupt, but only while that interrupt is enabled. A victim written back during the cache-flush instruction passes with no effect. An access error that is written back to memory uncorrected raises only the CRD interrupt.

The logged state consists of a status register, the block address, the two quadword syndromes and a sticky overflow flag. It holds until handler software clears it. The machine-check and CRD requests are registered levels that stay high until they are acknowledged or cleared.

Top module: `fill_ecc_err_log`

## Requirements
- R1: An event of kind 2'b00 (instruction fill) makes `ic_flush` and `ic_poison` high in the cycle after it is sampled, for that one cycle, with `ic_poison_ow` equal to the upper bits `evt_qw[2:1]` of the failing quadword index.
- R2: An instruction-fill event that finds the status at zero sets status bit 0. In the same cycle it loads `err_addr` with block address bits [42:6] and loads `err_syn0`/`err_syn1` with the quadword 0 and quadword 1 syndromes.
- R3: An instruction-fill event sets `mchk_req` on the next cycle. `mchk_req` then stays high until a cycle with `mchk_ack` high and no new instruction-fill event, and falls on the cycle after that.
- R4: An instruction-fill event also sets `crd_req` when `crd_en` is high, and leaves `crd_req` untouched when `crd_en` is low.
- R5: A data-fill event (kind 2'b01) with `crd_en` high sets status bit 1, logs the address and syndromes, and sets `crd_req`. With `crd_en` low it changes no output.
- R6: A flush-victim event (kind 2'b10) changes no register and raises no request.
- R7: A write-back access error (kind 2'b11) sets `crd_req` when `crd_en` is high and never changes status, address, syndromes or overflow.
- R8: A logging event that arrives while the status is non-zero leaves the status, address and syndromes as they are, and sets `err_ovf`. `err_ovf` stays set until `err_clr`.
- R9: `err_clr` zeroes status and overflow and leaves address and syndromes as they are. A logging event in the same cycle is logged as if the status were already zero.
- R10: `crd_clr` drops `crd_req` on the next cycle, unless a new CRD posting arrives in the same cycle, in which case `crd_req` stays high.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | A correctable error event is present this cycle |
| evt_kind | input | 2 | 00 instruction fill, 01 data fill, 10 flush victim, 11 write-back access error |
| evt_qw | input | 3 | Index of the failing quadword within the block |
| evt_addr | input | 37 | Physical block address bits [42:6] |
| evt_syn0 | input | 8 | Syndrome of quadword 0 of the failing octaword |
| evt_syn1 | input | 8 | Syndrome of quadword 1 of the failing octaword |
| crd_en | input | 1 | CRD interrupt enable |
| err_clr | input | 1 | Write-one-to-clear for status and overflow |
| crd_clr | input | 1 | Write-one-to-clear for the pending CRD interrupt |
| mchk_ack | input | 1 | Machine check taken |
| err_status | output | 4 | Bit 0 instruction-fill error, bit 1 data-fill error |
| err_ovf | output | 1 | Sticky flag: a later error was not logged |
| err_addr | output | 37 | Logged block address |
| err_syn0 | output | 8 | Logged quadword 0 syndrome |
| err_syn1 | output | 8 | Logged quadword 1 syndrome |
| mchk_req | output | 1 | Machine-check request level |
| crd_req | output | 1 | CRD interrupt request level |
| ic_flush | output | 1 | One-cycle instruction-cache flush request |
| ic_poison | output | 1 | One-cycle request to force bad parity on an octaword |
| ic_poison_ow | output | 2 | Octaword to poison |

## Verification
The hardest case to reach from the ports is a collision. A clear or acknowledge lands in the same cycle as a new event: `err_clr` together with a second logging event while the first is still held, `crd_clr` together with a fresh CRD posting, or `mchk_ack` together with another instruction fill. Random stimulus rarely lines these up, so directed sequences first fill the log and then present the clear and the event in one cycle. After that, a long seeded random run keeps events dense and clears sparse, which drives the log into overflow many times, and every output is compared with a reference model on each cycle.

// File: rtl/fel_pkg.sv
package fel_pkg;

   typedef enum logic [1:0] {
      EV_IFILL    = 2'b00,
      EV_DFILL    = 2'b01,
      EV_VICFLUSH = 2'b10,
      EV_WBACC    = 2'b11
   } fel_evt_e;

   typedef struct packed {
      logic log_err;     // write status/address/syndromes (or overflow)
      logic is_istream;  // which status bit to set
      logic want_mchk;   // raise machine check
      logic want_crd;    // post CRD interrupt
      logic want_icfix;  // flush Icache and poison octaword parity
   } fel_act_t;

   localparam int unsigned ST_IFILL_BIT = 0;
   localparam int unsigned ST_DFILL_BIT = 1;

endpackage

// File: rtl/fel_classify.sv
module fel_classify
   import fel_pkg::*;
#(
   parameter bit SHADOW_CRD = 1'b1
) (
   input  logic       evt_valid,
   input  logic [1:0] evt_kind,
   input  logic       crd_en,
   output fel_act_t   act
);

   fel_evt_e kind;
   assign kind = fel_evt_e'(evt_kind);

   logic shadow_crd;

   generate
      if (SHADOW_CRD) begin : g_shadow
         assign shadow_crd = crd_en;
      end else begin : g_no_shadow
         assign shadow_crd = 1'b0;
      end
   endgenerate

   always_comb begin
      act = '0;
      if (evt_valid) begin
         unique case (kind)
            EV_IFILL: begin
               act.log_err    = 1'b1;
               act.is_istream = 1'b1;
               act.want_mchk  = 1'b1;
               act.want_crd   = shadow_crd;
               act.want_icfix = 1'b1;
            end
            EV_DFILL: begin
               act.log_err  = crd_en;
               act.want_crd = crd_en;
            end
            EV_VICFLUSH: begin
               act = '0;
            end
            EV_WBACC: begin
               act.want_crd = crd_en;
            end
            default: act = '0;
         endcase
      end
   end

   always_comb begin
      if (act.want_mchk) assert (act.want_icfix)
         else $error("p_mchk_needs_icfix_r1");
   end

endmodule

// File: rtl/fel_req_hold.sv
module fel_req_hold #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic req_o
);

   logic req_d;

   generate
      if (SET_WINS) begin : g_set_wins
         always_comb begin
            if (set_i)      req_d = 1'b1;
            else if (clr_i) req_d = 1'b0;
            else            req_d = req_o;
         end
      end else begin : g_clr_wins
         always_comb begin
            if (clr_i)      req_d = 1'b0;
            else if (set_i) req_d = 1'b1;
            else            req_d = req_o;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_o <= 1'b0;
      else        req_o <= req_d;
   end

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !clr_i) |=> req_o);

   p_req_rise_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(set_i));

endmodule

// File: rtl/fel_icache_ctl.sv
module fel_icache_ctl #(
   parameter int unsigned QW_IDX_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire,
   input  logic [QW_IDX_W-1:0] qw_idx,
   output logic                flush_o,
   output logic                poison_o,
   output logic [QW_IDX_W-2:0] poison_ow_o
);

   localparam int unsigned OW_W = QW_IDX_W - 1;

   logic [OW_W-1:0] ow_of_qw;
   assign ow_of_qw = qw_idx[QW_IDX_W-1:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_o     <= 1'b0;
         poison_o    <= 1'b0;
         poison_ow_o <= '0;
      end else begin
         flush_o  <= fire;
         poison_o <= fire;
         if (fire) poison_ow_o <= ow_of_qw;
      end
   end

   p_pulse_after_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (flush_o && poison_o));

   p_no_pulse_without_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !flush_o);

endmodule

// File: rtl/fel_log_regs.sv
module fel_log_regs
   import fel_pkg::*;
#(
   parameter int unsigned ADDR_W   = 37,
   parameter int unsigned SYN_W    = 8,
   parameter int unsigned STAT_W   = 4,
   parameter bit          KEEP_OVF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fel_act_t          act,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [SYN_W-1:0]  syn0,
   input  logic [SYN_W-1:0]  syn1,
   input  logic              err_clr,
   output logic [STAT_W-1:0] status_o,
   output logic              ovf_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [SYN_W-1:0]  syn0_o,
   output logic [SYN_W-1:0]  syn1_o
);

   logic              held_empty;
   logic              take;
   logic              spill;
   logic [STAT_W-1:0] status_d;
   logic [STAT_W-1:0] new_code;

   // A clear in the same cycle frees the log for the incoming error.
   assign held_empty = err_clr || (status_o == '0);
   assign take       = act.log_err && held_empty;
   assign spill      = act.log_err && !held_empty;

   always_comb begin
      new_code = '0;
      if (act.is_istream) new_code[ST_IFILL_BIT] = 1'b1;
      else                new_code[ST_DFILL_BIT] = 1'b1;
   end

   always_comb begin
      status_d = status_o;
      if (err_clr) status_d = '0;
      if (take)    status_d = new_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_o <= '0;
         addr_o   <= '0;
         syn0_o   <= '0;
         syn1_o   <= '0;
      end else begin
         status_o <= status_d;
         if (take) begin
            addr_o <= fill_addr;
            syn0_o <= syn0;
            syn1_o <= syn1;
         end
      end
   end

   generate
      if (KEEP_OVF) begin : g_ovf
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ovf_o <= 1'b0;
            else if (spill)   ovf_o <= 1'b1;
            else if (err_clr) ovf_o <= 1'b0;
         end
      end else begin : g_no_ovf
         assign ovf_o = 1'b0;
      end
   endgenerate

   p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o != '0) && !err_clr) |=> ($stable(addr_o) && $stable(syn0_o) && $stable(syn1_o)));

   p_status_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o != '0) && !err_clr) |=> $stable(status_o));

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !err_clr) |=> ovf_o);

   p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !act.log_err) |=> (status_o == '0));

   p_one_hot_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(status_o));

endmodule

// File: rtl/fill_ecc_err_log.sv
module fill_ecc_err_log
   import fel_pkg::*;
#(
   parameter int unsigned ADDR_HI    = 42,
   parameter int unsigned ADDR_LO    = 6,
   parameter int unsigned SYN_W      = 8,
   parameter int unsigned STAT_W     = 4,
   parameter bit          SHADOW_CRD = 1'b1,
   parameter bit          KEEP_OVF   = 1'b1,
   localparam int unsigned ADDR_W    = ADDR_HI - ADDR_LO + 1,
   localparam int unsigned QW_IDX_W  = ADDR_LO - 3,
   localparam int unsigned OW_W      = QW_IDX_W - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_valid,
   input  logic [1:0]          evt_kind,
   input  logic [QW_IDX_W-1:0] evt_qw,
   input  logic [ADDR_W-1:0]   evt_addr,
   input  logic [SYN_W-1:0]    evt_syn0,
   input  logic [SYN_W-1:0]    evt_syn1,
   input  logic                crd_en,
   input  logic                err_clr,
   input  logic                crd_clr,
   input  logic                mchk_ack,
   output logic [STAT_W-1:0]   err_status,
   output logic                err_ovf,
   output logic [ADDR_W-1:0]   err_addr,
   output logic [SYN_W-1:0]    err_syn0,
   output logic [SYN_W-1:0]    err_syn1,
   output logic                mchk_req,
   output logic                crd_req,
   output logic                ic_flush,
   output logic                ic_poison,
   output logic [OW_W-1:0]     ic_poison_ow
);

   generate
      if (ADDR_LO < 5) begin : g_bad_lo
         $error("fill_ecc_err_log: block must hold at least two octawords");
      end
      if (ADDR_HI <= ADDR_LO) begin : g_bad_hi
         $error("fill_ecc_err_log: address range is empty");
      end
      if (STAT_W < 2) begin : g_bad_stat
         $error("fill_ecc_err_log: status needs two bits");
      end
      if (SYN_W < 1) begin : g_bad_syn
         $error("fill_ecc_err_log: syndrome width must be positive");
      end
   endgenerate

   fel_act_t act;

   fel_classify #(
      .SHADOW_CRD (SHADOW_CRD)
   ) u_classify (
      .evt_valid (evt_valid),
      .evt_kind  (evt_kind),
      .crd_en    (crd_en),
      .act       (act)
   );

   fel_log_regs #(
      .ADDR_W   (ADDR_W),
      .SYN_W    (SYN_W),
      .STAT_W   (STAT_W),
      .KEEP_OVF (KEEP_OVF)
   ) u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (act),
      .fill_addr (evt_addr),
      .syn0      (evt_syn0),
      .syn1      (evt_syn1),
      .err_clr   (err_clr),
      .status_o  (err_status),
      .ovf_o     (err_ovf),
      .addr_o    (err_addr),
      .syn0_o    (err_syn0),
      .syn1_o    (err_syn1)
   );

   fel_req_hold #(
      .SET_WINS (1'b1)
   ) u_mchk (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (act.want_mchk),
      .clr_i (mchk_ack),
      .req_o (mchk_req)
   );

   fel_req_hold #(
      .SET_WINS (1'b1)
   ) u_crd (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (act.want_crd),
      .clr_i (crd_clr),
      .req_o (crd_req)
   );

   fel_icache_ctl #(
      .QW_IDX_W (QW_IDX_W)
   ) u_icache (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (act.want_icfix),
      .qw_idx      (evt_qw),
      .flush_o     (ic_flush),
      .poison_o    (ic_poison),
      .poison_ow_o (ic_poison_ow)
   );

   p_flush_with_mchk_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ic_flush |-> mchk_req);

   p_mchk_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mchk_req) |-> $past(evt_valid && (evt_kind == EV_IFILL)));

   p_victim_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && (evt_kind == EV_VICFLUSH) && !err_clr) |=>
         ($stable(err_status) && $stable(err_addr) && $stable(err_ovf) && !ic_flush));

   p_wb_nolog_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && (evt_kind == EV_WBACC) && !err_clr) |=>
         ($stable(err_status) && $stable(err_ovf) && $stable(err_addr)));

   p_crd_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crd_req) |-> $past(crd_en));

endmodule

// File: tb/fill_ecc_err_log_bench.sv
module fill_ecc_err_log_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [1:0]  evt_kind = '0;
   logic [2:0]  evt_qw = '0;
   logic [36:0] evt_addr = '0;
   logic [7:0]  evt_syn0 = '0;
   logic [7:0]  evt_syn1 = '0;
   logic        crd_en = 1'b0;
   logic        err_clr = 1'b0;
   logic        crd_clr = 1'b0;
   logic        mchk_ack = 1'b0;
   logic [3:0]  err_status;
   logic        err_ovf;
   logic [36:0] err_addr;
   logic [7:0]  err_syn0;
   logic [7:0]  err_syn1;
   logic        mchk_req;
   logic        crd_req;
   logic        ic_flush;
   logic        ic_poison;
   logic [1:0]  ic_poison_ow;

   fill_ecc_err_log u_fill_ecc_err_log (
      .clk (clk), .rst_n (rst_n),
      .evt_valid (evt_valid), .evt_kind (evt_kind), .evt_qw (evt_qw),
      .evt_addr (evt_addr), .evt_syn0 (evt_syn0), .evt_syn1 (evt_syn1),
      .crd_en (crd_en), .err_clr (err_clr), .crd_clr (crd_clr), .mchk_ack (mchk_ack),
      .err_status (err_status), .err_ovf (err_ovf), .err_addr (err_addr),
      .err_syn0 (err_syn0), .err_syn1 (err_syn1), .mchk_req (mchk_req),
      .crd_req (crd_req), .ic_flush (ic_flush), .ic_poison (ic_poison),
      .ic_poison_ow (ic_poison_ow)
   );

   always #2 clk = ~clk;  // 250 MHz

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference model state
   logic [3:0]  m_st = '0;
   logic        m_ovf = 1'b0;
   logic [36:0] m_addr = '0;
   logic [7:0]  m_s0 = '0, m_s1 = '0;
   logic        m_mchk = 1'b0, m_crd = 1'b0, m_flush = 1'b0;
   logic [1:0]  m_ow = '0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic bool_t_dummy();
      return 1'b0;
   endfunction

   // Next-state of the reference model, written from the requirements.
   task automatic model_step();
      logic logs, crd_set;
      logs    = evt_valid && (evt_kind == 2'b00 || (evt_kind == 2'b01 && crd_en));
      crd_set = evt_valid && crd_en && (evt_kind != 2'b10);
      if (err_clr) begin m_st = '0; m_ovf = 1'b0; end
      if (logs) begin
         if (m_st == '0) begin
            m_st   = (evt_kind == 2'b00) ? 4'b0001 : 4'b0010;
            m_addr = evt_addr; m_s0 = evt_syn0; m_s1 = evt_syn1;
         end else begin
            m_ovf = 1'b1;
         end
      end
      if (evt_valid && evt_kind == 2'b00) m_mchk = 1'b1;
      else if (mchk_ack)                  m_mchk = 1'b0;
      if (crd_set)      m_crd = 1'b1;
      else if (crd_clr) m_crd = 1'b0;
      m_flush = evt_valid && evt_kind == 2'b00;
      if (m_flush) m_ow = evt_qw[2:1];
   endtask

   task automatic compare(input string tag);
      check(err_status == m_st, tag, "status", 64'(err_status), 64'(m_st));
      check(err_addr == m_addr, tag, "addr", 64'(err_addr), 64'(m_addr));
      check({err_syn1, err_syn0} == {m_s1, m_s0}, tag, "syndromes",
            64'({err_syn1, err_syn0}), 64'({m_s1, m_s0}));
      check(err_ovf == m_ovf, "R8", "overflow", 64'(err_ovf), 64'(m_ovf));
      check(mchk_req == m_mchk, "R3", "mchk_req", 64'(mchk_req), 64'(m_mchk));
      check(crd_req == m_crd, "R10", "crd_req", 64'(crd_req), 64'(m_crd));
      check(ic_flush == m_flush && ic_poison == m_flush, "R1", "flush/poison",
            64'({ic_flush, ic_poison}), 64'({m_flush, m_flush}));
      if (m_flush)
         check(ic_poison_ow == m_ow, "R1", "poison octaword", 64'(ic_poison_ow), 64'(m_ow));
   endtask

   task automatic drive(input bit v, input logic [1:0] k, input logic [2:0] qw,
                        input logic [36:0] a, input logic [7:0] s0, input logic [7:0] s1,
                        input bit en, input bit ec, input bit cc, input bit ma,
                        input string tag);
      @(negedge clk);
      evt_valid = v; evt_kind = k; evt_qw = qw; evt_addr = a;
      evt_syn0 = s0; evt_syn1 = s1; crd_en = en;
      err_clr = ec; crd_clr = cc; mchk_ack = ma;
      model_step();
      @(posedge clk);
      #1;
      compare(tag);
   endtask

   task automatic idle(input string tag);
      drive(1'b0, 2'b00, 3'd0, 37'd0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      #1;
      // R11: reset state
      check({err_status, err_ovf, err_addr, err_syn0, err_syn1} == '0, "R11", "log at reset",
            64'(err_addr), 64'd0);
      check({mchk_req, crd_req, ic_flush, ic_poison} == 4'b0, "R11", "requests at reset",
            64'({mchk_req, crd_req, ic_flush, ic_poison}), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2, R4: instruction fill with CRD enabled
      drive(1, 2'b00, 3'd5, 37'h1_2345_6789, 8'hA5, 8'h3C, 1, 0, 0, 0, "R2");
      check(crd_req == 1'b1, "R4", "shadow CRD with ifill", 64'(crd_req), 64'd1);
      idle("R1");
      // R3: ack drops machine check
      drive(0, 2'b00, 3'd0, 37'd0, 8'd0, 8'd0, 0, 0, 0, 1, "R3");
      check(mchk_req == 1'b0, "R3", "mchk after ack", 64'(mchk_req), 64'd0);
      // R8: second error is not logged, overflow set
      drive(1, 2'b00, 3'd2, 37'h0_0BAD_0000, 8'h11, 8'h22, 0, 0, 1, 0, "R8");
      check(err_addr == 37'h1_2345_6789, "R8", "first addr kept", 64'(err_addr), 64'h123456789);
      // R3: ack and new ifill in same cycle keeps mchk
      drive(1, 2'b00, 3'd7, 37'h5, 8'h01, 8'h02, 0, 0, 0, 1, "R3");
      // R9: clear with same-cycle data fill logs the new one
      drive(1, 2'b01, 3'd1, 37'h0_0FED_CBA0, 8'h77, 8'h88, 1, 1, 0, 1, "R9");
      check(err_status == 4'b0010, "R9", "status after clear+dfill", 64'(err_status), 64'd2);
      // R9: plain clear
      drive(0, 2'b00, 3'd0, 37'd0, 8'd0, 8'd0, 0, 1, 1, 0, "R9");
      // R10: clear and new CRD posting in same cycle
      drive(1, 2'b11, 3'd0, 37'h7, 8'h9, 8'h9, 1, 0, 1, 0, "R10");
      check(crd_req == 1'b1, "R10", "set wins over clear", 64'(crd_req), 64'd1);
      drive(0, 2'b00, 3'd0, 37'd0, 8'd0, 8'd0, 0, 0, 1, 0, "R10");
      // R7: write-back error leaves log empty
      drive(1, 2'b11, 3'd3, 37'h42, 8'h5, 8'h6, 1, 0, 0, 0, "R7");
      // R5: data fill with CRD disabled is ignored
      drive(0, 2'b00, 3'd0, 37'd0, 8'd0, 8'd0, 0, 0, 1, 0, "R5");
      drive(1, 2'b01, 3'd4, 37'h99, 8'hEE, 8'hDD, 0, 0, 0, 0, "R5");
      check(crd_req == 1'b0 && err_status == 4'b0, "R5", "dfill without enable",
            64'({crd_req, err_status}), 64'd0);
      // R6: flush victim ignored
      drive(1, 2'b10, 3'd6, 37'h1234, 8'h12, 8'h34, 1, 0, 0, 0, "R6");
      check(crd_req == 1'b0 && err_status == 4'b0, "R6", "victim quiet",
            64'({crd_req, err_status}), 64'd0);
      // R4: ifill without enable posts no CRD
      drive(1, 2'b00, 3'd3, 37'h1F, 8'h4, 8'h8, 0, 0, 0, 0, "R4");
      check(crd_req == 1'b0, "R4", "no CRD when disabled", 64'(crd_req), 64'd0);

      // Random phase: dense events, sparse clears
      for (int i = 0; i < 3000; i++) begin
         logic [1:0] k;
         string t;
         k = 2'($urandom_range(0, 3));
         case (k)
            2'b00: t = "R2";
            2'b01: t = "R5";
            2'b10: t = "R6";
            default: t = "R7";
         endcase
         drive(($urandom_range(0, 3) != 0), k, 3'($urandom), 37'({$urandom, $urandom}),
               8'($urandom), 8'($urandom), ($urandom_range(0, 2) != 0),
               ($urandom_range(0, 15) == 0), ($urandom_range(0, 7) == 0),
               ($urandom_range(0, 5) == 0), t);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule